// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This block compares two 128-bit operands, each holding four IEEE single-precision values, and turns the outcome into lane masks. A 4-bit predicate code picks one of twelve relations. Each compared lane of the result is all ones when the relation holds and all zeros when it does not. Any lane that holds a NaN makes its pair unordered. The negated relations and the unordered test are true for such a pair, and the plain relations and the ordered test are false.

A mode input picks between packed operation and scalar operation. Packed operation evaluates all four lane pairs in parallel. Scalar operation evaluates only the lowest pair and copies the three upper lanes from the first operand. The result and an illegal-predicate flag are registered: they appear at the rising clock edge that follows the inputs. The unit is meant to sit in a vector datapath, where the mask it produces feeds blend or select logic.

Top module: `vec_fcmp_unit`

## Requirements
- R1: While rst_ni is low, res_o is all zeros and illegal_pred_o is 0.
- R2: res_o and illegal_pred_o reflect the inputs that were present at the preceding rising edge of clk_i, with one cycle of latency.
- R3: Every compared lane of res_o is either 32'hFFFFFFFF (relation true) or 32'h00000000 (relation false).
- R4: pred_i selects the relation: 0 equal, 1 less, 2 less-or-equal, 3 greater, 4 greater-or-equal, 5 unordered, 6 not-equal, 7 not-less, 8 not-less-or-equal, 9 not-greater, 10 not-greater-or-equal, 11 ordered. Each relation is read as "lane of src_a_i relation lane of src_b_i".
- R5: A value is NaN when bits [30:23] are all ones and bits [22:0] are nonzero. A pair is unordered when either value is NaN. For an unordered pair, codes 0–4 and 11 give false, and codes 5–10 give true.
- R6: +0 (32'h00000000) and −0 (32'h80000000) compare as equal.
- R7: Ordered values follow numeric order. Sign bit 31 is taken into account, infinities (exponent all ones, mantissa zero) lie beyond every finite value, and denormals order by magnitude.
- R8: With scalar_i = 0, lane i occupies bits [32i+31:32i]. Each of the four lanes is evaluated independently of the others.
- R9: With scalar_i = 1, only lane 0 is evaluated, and bits [127:32] of res_o copy bits [127:32] of src_a_i.
- R10: Codes 12–15 are illegal. For these codes illegal_pred_o is 1 and all 128 bits of res_o are zero, in both modes. For codes 0–11 illegal_pred_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_i | input | 128 | First operand, four single-precision lanes |
| src_b_i | input | 128 | Second operand, four single-precision lanes |
| pred_i | input | 4 | Predicate code |
| scalar_i | input | 1 | 1 selects scalar mode, 0 selects packed mode |
| res_o | output | 128 | Registered lane masks (with upper lanes passed through in scalar mode) |
| illegal_pred_o | output | 1 | Registered flag for a predicate code of 12 or above |

## Verification
Scalar pass-through and illegal-predicate zeroing can apply in the same cycle, and each pulls the upper result lanes a different way. The bench provokes this by applying codes 12 to 15 with scalar_i high while the upper lanes of src_a_i hold nonzero data. It expects all 128 result bits to be zero and the flag to be set. A second case that can arise in one cycle is an unordered lane sitting beside ordered lanes in one packed operation. Every predicate is swept over such mixed vectors, and each lane is judged against a reference that orders values by a signed-magnitude key.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int NUM_PRED = 12;
  localparam int PRED_W   = 4;

  typedef enum logic [PRED_W-1:0] {
    PR_EQ   = 4'd0,
    PR_LT   = 4'd1,
    PR_LE   = 4'd2,
    PR_GT   = 4'd3,
    PR_GE   = 4'd4,
    PR_UNO  = 4'd5,
    PR_NEQ  = 4'd6,
    PR_NLT  = 4'd7,
    PR_NLE  = 4'd8,
    PR_NGT  = 4'd9,
    PR_NGE  = 4'd10,
    PR_ORD  = 4'd11
  } pred_e;

  typedef logic [NUM_PRED-1:0] rel_vec_t;
endpackage

// File: rtl/fcmp_pred_dec.sv
module fcmp_pred_dec
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] pred_i,
  output rel_vec_t          sel_o,
  output logic              illegal_o
);
  always_comb begin
    illegal_o = (int'(pred_i) >= NUM_PRED);
    sel_o     = '0;
    if (!illegal_o) sel_o[pred_i] = 1'b1;
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output rel_vec_t     rel_o
);
  localparam int MAG_W = EXP_W + MAN_W;

  logic             sa, sb, nan_a, nan_b, unord, both_zero;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             eq_raw, lt_raw, eq, lt, gt;

  assign sa    = a_i[W-1];
  assign sb    = b_i[W-1];
  assign mag_a = a_i[MAG_W-1:0];
  assign mag_b = b_i[MAG_W-1:0];
  assign nan_a = (&a_i[MAG_W-1:MAN_W]) && (|a_i[MAN_W-1:0]);
  assign nan_b = (&b_i[MAG_W-1:MAN_W]) && (|b_i[MAN_W-1:0]);
  assign unord = nan_a | nan_b;
  assign both_zero = ~|mag_a & ~|mag_b;

  assign eq_raw = (a_i == b_i) | both_zero;

  // sign-magnitude ordering on raw bits
  always_comb begin
    if (both_zero)     lt_raw = 1'b0;
    else if (sa != sb) lt_raw = sa;
    else if (!sa)      lt_raw = (mag_a < mag_b);
    else               lt_raw = (mag_a > mag_b);
  end

  assign eq = ~unord & eq_raw;
  assign lt = ~unord & lt_raw;
  assign gt = ~unord & ~eq_raw & ~lt_raw;

  always_comb begin
    rel_o         = '0;
    rel_o[PR_EQ]  = eq;
    rel_o[PR_LT]  = lt;
    rel_o[PR_LE]  = eq | lt;
    rel_o[PR_GT]  = gt;
    rel_o[PR_GE]  = eq | gt;
    rel_o[PR_UNO] = unord;
    rel_o[PR_NEQ] = ~eq;
    rel_o[PR_NLT] = ~lt;
    rel_o[PR_NLE] = ~(eq | lt);
    rel_o[PR_NGT] = ~gt;
    rel_o[PR_NGE] = ~(eq | gt);
    rel_o[PR_ORD] = ~unord;
  end
endmodule

// File: rtl/vec_fcmp_unit.sv
module vec_fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int LANE_W = 1 + EXP_W + MAN_W,
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              scalar_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              illegal_pred_o
);
  rel_vec_t         sel;
  logic             illegal;
  logic [LANES-1:0] hit;
  logic [VEC_W-1:0] res_d;

  fcmp_pred_dec u_dec (
    .pred_i    (pred_i),
    .sel_o     (sel),
    .illegal_o (illegal)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rel_vec_t rel;

    fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .a_i   (src_a_i[i*LANE_W +: LANE_W]),
      .b_i   (src_b_i[i*LANE_W +: LANE_W]),
      .rel_o (rel)
    );

    assign hit[i] = |(rel & sel);

    if (i == 0) begin : g_low
      assign res_d[i*LANE_W +: LANE_W] = {LANE_W{hit[i]}};
    end else begin : g_up
      // scalar mode forwards upper lanes; illegal code wins
      assign res_d[i*LANE_W +: LANE_W] =
        illegal  ? '0 :
        scalar_i ? src_a_i[i*LANE_W +: LANE_W] : {LANE_W{hit[i]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o          <= '0;
      illegal_pred_o <= 1'b0;
    end else begin
      res_o          <= res_d;
      illegal_pred_o <= illegal;
    end
  end
endmodule

// File: rtl/vec_fcmp_chk.sv
module vec_fcmp_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int VEC_W = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VEC_W-1:0] src_a_i,
  input logic [VEC_W-1:0] src_b_i,
  input logic [3:0]       pred_i,
  input logic             scalar_i,
  input logic [VEC_W-1:0] res_o,
  input logic             illegal_pred_o
);
  logic a0_nan;
  assign a0_nan = (&src_a_i[30:23]) && (|src_a_i[22:0]) && (src_b_i[31:0] == src_b_i[31:0]);

  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_clear_chk: assert (res_o == '0 && !illegal_pred_o);
    end
  end

  // R3
  lane0_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (res_o[LANE_W-1:0] == '0 || res_o[LANE_W-1:0] == '1));

  for (genvar i = 1; i < LANES; i++) begin : g_mask
    // R3
    upper_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !scalar_i |=> (res_o[i*LANE_W +: LANE_W] == '0 || res_o[i*LANE_W +: LANE_W] == '1));
  end

  // R10
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_i >= 4'd12) |=> (illegal_pred_o && res_o == '0));

  // R10
  legal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_i < 4'd12) |=> !illegal_pred_o);

  // R9
  scalar_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scalar_i && pred_i < 4'd12) |=> (res_o[VEC_W-1:LANE_W] == $past(src_a_i[VEC_W-1:LANE_W])));

  // R5
  nan_eq_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0_nan && pred_i == 4'd0) |=> (res_o[LANE_W-1:0] == '0));

  // R5
  nan_uno_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0_nan && pred_i == 4'd5) |=> (res_o[LANE_W-1:0] == '1));
endmodule

bind vec_fcmp_unit vec_fcmp_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .src_a_i        (src_a_i),
  .src_b_i        (src_b_i),
  .pred_i         (pred_i),
  .scalar_i       (scalar_i),
  .res_o          (res_o),
  .illegal_pred_o (illegal_pred_o)
);

// File: tb/vec_fcmp_unit_bench.sv
`timescale 1ns/1ps
module vec_fcmp_unit_bench;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, MONE = 32'hBF80_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000, MAXF = 32'h7F7F_FFFF;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, NNAN = 32'hFFC0_0001, SNAN = 32'h7F80_0001;
  localparam logic [31:0] DEN1 = 32'h0000_0001, DEN2 = 32'h0000_0002, MDEN = 32'h8000_0001;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] src_a_i = '0, src_b_i = '0;
  logic [3:0]   pred_i = '0;
  logic         scalar_i = 1'b0;
  logic [127:0] res_o;
  logic         illegal_pred_o;

  int n_vec = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  vec_fcmp_unit u_vec_fcmp_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .pred_i(pred_i), .scalar_i(scalar_i), .res_o(res_o), .illegal_pred_o(illegal_pred_o)
  );

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic signed [32:0] okey(logic [31:0] x);
    logic signed [32:0] m;
    m = $signed({2'b00, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  function automatic bit ref_rel(logic [31:0] a, logic [31:0] b, int p);
    bit u;
    logic signed [32:0] ka, kb;
    u = is_nan(a) || is_nan(b);
    ka = okey(a);
    kb = okey(b);
    case (p)
      0: return !u && ka == kb;
      1: return !u && ka < kb;
      2: return !u && ka <= kb;
      3: return !u && ka > kb;
      4: return !u && ka >= kb;
      5: return u;
      6: return u || ka != kb;
      7: return u || !(ka < kb);
      8: return u || !(ka <= kb);
      9: return u || !(ka > kb);
      10: return u || !(ka >= kb);
      11: return !u;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] b, int p, bit sc);
    logic [127:0] r;
    r = '0;
    if (p >= 12) return r;
    for (int i = 0; i < 4; i++) begin
      if (sc && i > 0) r[i*32 +: 32] = a[i*32 +: 32];
      else r[i*32 +: 32] = {32{ref_rel(a[i*32 +: 32], b[i*32 +: 32], p)}};
    end
    return r;
  endfunction

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input int p,
                       input bit sc, input string req);
    logic [127:0] exp_r;
    bit exp_il;
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; pred_i = 4'(p); scalar_i = sc;
    exp_r = ref_vec(a, b, p, sc);
    exp_il = (p >= 12);
    @(negedge clk_i);
    n_vec++;
    if (res_o !== exp_r || illegal_pred_o !== exp_il) begin
      n_bad++;
      $display("FAIL %s pred=%0d scalar=%0b: got res=%h ill=%b, expected res=%h ill=%b",
               req, p, sc, res_o, illegal_pred_o, exp_r, exp_il);
    end
  endtask

  task automatic t_reset;
    src_a_i = {4{ONE}}; src_b_i = {4{ONE}}; pred_i = 4'd0;
    repeat (2) @(negedge clk_i);
    n_vec++;
    if (res_o !== '0 || illegal_pred_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got res=%h ill=%b, expected 0 0", res_o, illegal_pred_o);
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_order;  // R2 R4 R7 R8
    for (int p = 0; p < 12; p++) begin
      apply({MAXF, TWO, MONE, ONE}, {PINF, TWO, ONE, TWO}, p, 1'b0, "R4/R8 order");
      apply({NINF, DEN1, MDEN, PINF}, {MONE, DEN2, NZ, MAXF}, p, 1'b0, "R7 inf/denorm");
    end
  endtask

  task automatic t_nan;  // R5
    for (int p = 0; p < 12; p++) begin
      apply({ONE, NNAN, SNAN, QNAN}, {QNAN, ONE, SNAN, PINF}, p, 1'b0, "R5 nan");
      apply({QNAN, TWO, NINF, PZ}, {ONE, TWO, QNAN, NNAN}, p, 1'b0, "R5 nan mix");
    end
  endtask

  task automatic t_zero;  // R6
    for (int p = 0; p < 12; p++)
      apply({NZ, PZ, NZ, PZ}, {NZ, PZ, PZ, NZ}, p, 1'b0, "R6 signed zero");
  endtask

  task automatic t_scalar;  // R9
    for (int p = 0; p < 12; p++) begin
      apply({QNAN, 32'h1234_5678, 32'hDEAD_BEEF, ONE}, {ONE, ONE, ONE, TWO}, p, 1'b1, "R9 scalar");
      apply({PZ, MONE, 32'hA5A5_A5A5, QNAN}, {NZ, NZ, NZ, ONE}, p, 1'b1, "R9 scalar nan");
    end
  endtask

  task automatic t_illegal;  // R10 with scalar pass-through collision
    for (int p = 12; p < 16; p++) begin
      apply({ONE, TWO, MONE, ONE}, {ONE, TWO, MONE, ONE}, p, 1'b0, "R10 packed");
      apply({32'hFFFF_FFFF, TWO, MAXF, ONE}, {ONE, ONE, ONE, ONE}, p, 1'b1, "R10 scalar");
    end
    apply({4{ONE}}, {4{ONE}}, 0, 1'b0, "R10 flag clears");
  endtask

  function automatic logic [31:0] rnd_val();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 8)
      0: v[30:23] = 8'hFF;
      1: v[30:0] = '0;
      2: v[30:23] = 8'h00;
      default: ;
    endcase
    return v;
  endfunction

  task automatic t_random;  // R3 R8
    logic [127:0] a, b;
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < 4; i++) begin
        a[i*32 +: 32] = rnd_val();
        b[i*32 +: 32] = ($urandom % 4 == 0) ? a[i*32 +: 32] : rnd_val();
      end
      apply(a, b, int'($urandom % 12), 1'b0, "R3/R8 random");
      n_vec++;
      for (int i = 0; i < 4; i++)
        if (res_o[i*32 +: 32] !== 32'h0 && res_o[i*32 +: 32] !== 32'hFFFF_FFFF) begin
          n_bad++;
          $display("FAIL R3 lane %0d: got %h, expected all-0 or all-1", i, res_o[i*32 +: 32]);
        end
    end
  endtask

  initial begin
    t_reset();
    t_order();
    t_nan();
    t_zero();
    t_scalar();
    t_illegal();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule